// File: doc/BRIEF.md
# Cache Range Maintenance Sequencer

The sequencer performs one cache maintenance operation (clean, invalidate, or clean-and-invalidate) over a range of virtual addresses. It works one 32-byte line at a time. A launch pulse captures a start address, an end address and an opcode. The low five bits of both addresses are dropped. The walk then visits every line from the start line up to and including the end line, in ascending order.

Each line takes two steps. First a translation request goes to an address-translation port, and the sequencer waits for its acknowledge. If the acknowledge reports no fault, a maintenance request goes to the cache port and is held until that port acknowledges it.

A walk ends in one of three ways, each marked by a single-cycle pulse:
- **Done:** the last line has been processed, or the range was empty.
- **Abort:** a translation faulted. The faulting line address is kept on an output.
- **Interrupt:** an interrupt request arrived while the next line was waiting for translation. No progress is saved, so a relaunch starts again from the start address.

Top module: `cache_range_seq`

## Requirements
- R1: The line address is bits [31:5] of an address, and bits [4:0] of the start and end inputs have no effect. Every `tr_addr_o` and `cm_addr_o` carries a line address with bits [4:0] zero.
- R2: A launch whose start line is not above its end line issues exactly one acknowledged maintenance request per line. The lines run from the start line to the end line inclusive, in ascending order, and the walk does not wrap at the top of the address space.
- R3: A launch whose start line is greater than its end line issues no translation and no maintenance request. `busy_o` stays low, and `done_o` pulses in the cycle after the launch is accepted.
- R4: Once raised, `tr_req_o` and `cm_req_o` stay high with a stable address, and for the cache port a stable opcode, until the matching acknowledge is sampled.
- R5: Every maintenance request is preceded by a translation request for the same line. That translation must be acknowledged with `tr_fault_i` low in the cycle before `cm_req_o` rises.
- R6: A translation acknowledged with `tr_fault_i` high ends the walk without a maintenance request for that line. `abort_o` pulses in the next cycle. `fault_o` is set and `fault_addr_o` holds that line address until the next accepted launch clears both to zero.
- R7: `irq_i` is sampled only while a translation request is pending, and it wins over a same-cycle acknowledge. It ends the walk with an `intr_o` pulse in the next cycle and no further requests. A later launch with the same inputs redoes the whole range from the start line.
- R8: `busy_o` rises in the cycle after an accepted launch of a non-empty range and stays high until the closing pulse. A launch while busy has no effect on the walk in progress.
- R9: The opcode encoding is 2'b01 clean, 2'b10 invalidate, 2'b11 clean-and-invalidate. It is carried unchanged on `cm_op_o`. A launch with 2'b00 is ignored: no request, no pulse, `busy_o` stays low.
- R10: At most one of `done_o`, `abort_o` and `intr_o` is high in any cycle, each lasts one cycle, and `busy_o` is low while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| launch_i | input | 1 | Launch a walk with the inputs below |
| op_i | input | 2 | Maintenance opcode |
| start_addr_i | input | 32 | First address of the range |
| end_addr_i | input | 32 | Address inside the last line of the range |
| irq_i | input | 1 | Interrupt request, stops the walk at a line boundary |
| tr_req_o | output | 1 | Translation request |
| tr_addr_o | output | 32 | Line address to translate |
| tr_ack_i | input | 1 | Translation acknowledge |
| tr_fault_i | input | 1 | Translation fault, valid with `tr_ack_i` |
| cm_req_o | output | 1 | Cache maintenance request |
| cm_addr_o | output | 32 | Line address for maintenance |
| cm_op_o | output | 2 | Opcode for maintenance |
| cm_ack_i | input | 1 | Cache maintenance acknowledge |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | Pulse: walk completed |
| abort_o | output | 1 | Pulse: walk stopped by a translation fault |
| intr_o | output | 1 | Pulse: walk stopped by an interrupt |
| fault_o | output | 1 | Last walk faulted |
| fault_addr_o | output | 32 | Line address of the fault |

## Verification
The assertions check the following on every cycle:
- request hold until acknowledge;
- line alignment of the issued addresses;
- the translation-before-maintenance ordering;
- the fault and interrupt reactions in the cycle after they are sampled;
- exclusivity of the closing pulses against `busy_o`.

Some properties span a whole walk, and only the bench scenarios can show them:
- the exact list of lines visited, and the inclusive end line;
- silence on reversed ranges and on the reserved opcode;
- the restart from the start line after an interrupt;
- immunity to a launch while busy;
- the absence of wrap at the top of the address space.

The bench sweeps these over many start/end pairs, all opcodes and several acknowledge latencies.

// File: rtl/cr_pkg.sv
package cr_pkg;
  typedef enum logic [1:0] {
    CR_OP_NONE  = 2'b00,
    CR_OP_CLEAN = 2'b01,
    CR_OP_INVAL = 2'b10,
    CR_OP_CLINV = 2'b11
  } cr_op_e;

  typedef enum logic [1:0] {
    CR_ST_IDLE   = 2'd0,
    CR_ST_XLATE  = 2'd1,
    CR_ST_CMAINT = 2'd2
  } cr_state_e;

  typedef enum logic [1:0] {
    CR_FIN_NONE  = 2'd0,
    CR_FIN_DONE  = 2'd1,
    CR_FIN_ABORT = 2'd2,
    CR_FIN_INTR  = 2'd3
  } cr_fin_e;
endpackage

// File: rtl/cr_line_stepper.sv
module cr_line_stepper #(
  parameter int unsigned LINE_W = 27
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [LINE_W-1:0] start_line_i,
  input  logic [LINE_W-1:0] end_line_i,
  output logic [LINE_W-1:0] cur_line_o,
  output logic              last_o,
  output logic              reversed_o
);
  logic [LINE_W-1:0] cur_q, end_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
      end_q <= '0;
    end else if (load_i) begin
      cur_q <= start_line_i;
      end_q <= end_line_i;
    end else if (step_i) begin
      cur_q <= cur_q + LINE_W'(1);
    end
  end

  // compare on live inputs so an empty range is known at launch
  assign reversed_o = start_line_i > end_line_i;
  // stop on equality, never increment past end: no wrap at top line
  assign last_o     = cur_q == end_q;
  assign cur_line_o = cur_q;
endmodule

// File: rtl/cr_walk_fsm.sv
module cr_walk_fsm
  import cr_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    launch_i,
  input  cr_op_e  op_i,
  input  logic    reversed_i,
  input  logic    irq_i,
  input  logic    tr_ack_i,
  input  logic    tr_fault_i,
  input  logic    cm_ack_i,
  input  logic    last_i,
  output logic    load_o,
  output logic    step_o,
  output logic    tr_req_o,
  output logic    cm_req_o,
  output logic    busy_o,
  output cr_op_e  op_o,
  output cr_fin_e fin_o
);
  cr_state_e state_q, state_d;
  cr_op_e    op_q;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    step_o  = 1'b0;
    fin_o   = CR_FIN_NONE;
    unique case (state_q)
      CR_ST_IDLE: begin
        if (launch_i && op_i != CR_OP_NONE) begin
          load_o = 1'b1;
          if (reversed_i) fin_o = CR_FIN_DONE;
          else            state_d = CR_ST_XLATE;
        end
      end
      CR_ST_XLATE: begin
        // interrupt only at a line boundary, ahead of translation
        if (irq_i) begin
          fin_o   = CR_FIN_INTR;
          state_d = CR_ST_IDLE;
        end else if (tr_ack_i) begin
          if (tr_fault_i) begin
            fin_o   = CR_FIN_ABORT;
            state_d = CR_ST_IDLE;
          end else begin
            state_d = CR_ST_CMAINT;
          end
        end
      end
      CR_ST_CMAINT: begin
        if (cm_ack_i) begin
          if (last_i) begin
            fin_o   = CR_FIN_DONE;
            state_d = CR_ST_IDLE;
          end else begin
            step_o  = 1'b1;
            state_d = CR_ST_XLATE;
          end
        end
      end
      default: state_d = CR_ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CR_ST_IDLE;
      op_q    <= CR_OP_NONE;
    end else begin
      state_q <= state_d;
      if (load_o) op_q <= op_i;
    end
  end

  assign tr_req_o = state_q == CR_ST_XLATE;
  assign cm_req_o = state_q == CR_ST_CMAINT;
  assign busy_o   = state_q != CR_ST_IDLE;
  assign op_o     = op_q;
endmodule

// File: rtl/cr_status.sv
module cr_status
  import cr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  cr_fin_e           fin_i,
  input  logic [ADDR_W-1:0] cur_addr_i,
  output logic              done_o,
  output logic              abort_o,
  output logic              intr_o,
  output logic              fault_o,
  output logic [ADDR_W-1:0] fault_addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o       <= 1'b0;
      abort_o      <= 1'b0;
      intr_o       <= 1'b0;
      fault_o      <= 1'b0;
      fault_addr_o <= '0;
    end else begin
      done_o  <= fin_i == CR_FIN_DONE;
      abort_o <= fin_i == CR_FIN_ABORT;
      intr_o  <= fin_i == CR_FIN_INTR;
      if (fin_i == CR_FIN_ABORT) begin
        fault_o      <= 1'b1;
        fault_addr_o <= cur_addr_i;
      end else if (accept_i) begin
        fault_o      <= 1'b0;
        fault_addr_o <= '0;
      end
    end
  end
endmodule

// File: rtl/cache_range_seq.sv
module cache_range_seq
  import cr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic [1:0]        op_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [ADDR_W-1:0] end_addr_i,
  input  logic              irq_i,
  output logic              tr_req_o,
  output logic [ADDR_W-1:0] tr_addr_o,
  input  logic              tr_ack_i,
  input  logic              tr_fault_i,
  output logic              cm_req_o,
  output logic [ADDR_W-1:0] cm_addr_o,
  output logic [1:0]        cm_op_o,
  input  logic              cm_ack_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              abort_o,
  output logic              intr_o,
  output logic              fault_o,
  output logic [ADDR_W-1:0] fault_addr_o
);
  localparam int unsigned LINE_W = ADDR_W - OFF_W;

  logic              load, step, last, reversed;
  logic [LINE_W-1:0] cur_line;
  logic [ADDR_W-1:0] cur_addr;
  cr_op_e            op_q;
  cr_fin_e           fin;
  logic              unused_low;

  assign unused_low = ^{start_addr_i[OFF_W-1:0], end_addr_i[OFF_W-1:0]};

  cr_line_stepper #(.LINE_W(LINE_W)) u_stepper (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .step_i      (step),
    .start_line_i(start_addr_i[ADDR_W-1:OFF_W]),
    .end_line_i  (end_addr_i[ADDR_W-1:OFF_W]),
    .cur_line_o  (cur_line),
    .last_o      (last),
    .reversed_o  (reversed)
  );

  cr_walk_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .launch_i  (launch_i),
    .op_i      (cr_op_e'(op_i)),
    .reversed_i(reversed),
    .irq_i     (irq_i),
    .tr_ack_i  (tr_ack_i),
    .tr_fault_i(tr_fault_i),
    .cm_ack_i  (cm_ack_i),
    .last_i    (last),
    .load_o    (load),
    .step_o    (step),
    .tr_req_o  (tr_req_o),
    .cm_req_o  (cm_req_o),
    .busy_o    (busy_o),
    .op_o      (op_q),
    .fin_o     (fin)
  );

  assign cur_addr  = {cur_line, {OFF_W{1'b0}}};
  assign tr_addr_o = cur_addr;
  assign cm_addr_o = cur_addr;
  assign cm_op_o   = op_q;

  cr_status #(.ADDR_W(ADDR_W)) u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (load),
    .fin_i       (fin),
    .cur_addr_i  (cur_addr),
    .done_o      (done_o),
    .abort_o     (abort_o),
    .intr_o      (intr_o),
    .fault_o     (fault_o),
    .fault_addr_o(fault_addr_o)
  );
endmodule

// File: rtl/cache_range_seq_chk.sv
module cache_range_seq_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              irq_i,
  input logic              tr_req_o,
  input logic [ADDR_W-1:0] tr_addr_o,
  input logic              tr_ack_i,
  input logic              tr_fault_i,
  input logic              cm_req_o,
  input logic [ADDR_W-1:0] cm_addr_o,
  input logic [1:0]        cm_op_o,
  input logic              cm_ack_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              abort_o,
  input logic              intr_o,
  input logic              fault_o,
  input logic [ADDR_W-1:0] fault_addr_o
);
  a_r1_line_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tr_req_o || cm_req_o) |-> (tr_addr_o[OFF_W-1:0] == '0 && cm_addr_o[OFF_W-1:0] == '0));

  a_r4_cm_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cm_req_o && !cm_ack_i) |=> (cm_req_o && $stable(cm_addr_o) && $stable(cm_op_o)));

  a_r4_tr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tr_req_o && !tr_ack_i && !irq_i) |=> (tr_req_o && $stable(tr_addr_o)));

  a_r5_xlate_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cm_req_o) |-> ($past(tr_req_o && tr_ack_i && !tr_fault_i && !irq_i)
                         && $past(tr_addr_o) == cm_addr_o));

  a_r6_fault_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tr_req_o && tr_ack_i && tr_fault_i && !irq_i) |=>
      (abort_o && fault_o && !cm_req_o && fault_addr_o == $past(tr_addr_o)));

  a_r7_intr_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tr_req_o && irq_i) |=> (intr_o && !tr_req_o && !cm_req_o));

  a_r8_req_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tr_req_o || cm_req_o) |-> busy_o);

  a_r9_op_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cm_req_o |-> cm_op_o != 2'b00);

  a_r10_one_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, abort_o, intr_o}) && ((done_o || abort_o || intr_o) -> !busy_o));

  a_r10_pulse_short: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || abort_o || intr_o) |=> !(done_o || abort_o || intr_o));
endmodule

bind cache_range_seq cache_range_seq_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (.*);

// File: tb/cache_range_seq_bench.sv
module cache_range_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          launch_i = 1'b0;
  logic [1:0]    op_i = 2'b00;
  logic [AW-1:0] start_addr_i = '0, end_addr_i = '0;
  logic          irq_i = 1'b0;
  logic          tr_req_o, tr_ack_i = 1'b0, tr_fault_i = 1'b0;
  logic [AW-1:0] tr_addr_o, cm_addr_o, fault_addr_o;
  logic          cm_req_o, cm_ack_i = 1'b0;
  logic [1:0]    cm_op_o;
  logic          busy_o, done_o, abort_o, intr_o, fault_o;

  cache_range_seq u_cache_range_seq (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int total = 0, bad = 0, cycles = 0;
  int lat = 0, tr_cnt = 0, cm_cnt = 0;
  bit fault_en = 0;
  logic [AW-1:0] fault_line = '0;
  int irq_at = -1;
  logic [AW-1:0] log_addr [0:63];
  logic [1:0]    log_op   [0:63];
  int log_n = 0, tr_seen = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // responders: acknowledge after lat cycles; fault/irq by bench configuration
  always @(negedge clk_i) begin
    if (tr_req_o) begin
      tr_ack_i   = tr_cnt >= lat;
      tr_fault_i = fault_en && tr_addr_o[AW-1:5] == fault_line[AW-1:5];
      irq_i      = irq_at >= 0 && log_n == irq_at;
      tr_cnt++;
    end else begin
      tr_ack_i = 0; tr_fault_i = 0; irq_i = 0; tr_cnt = 0;
    end
    if (cm_req_o) begin
      cm_ack_i = cm_cnt >= lat;
      cm_cnt++;
    end else begin
      cm_ack_i = 0; cm_cnt = 0;
    end
  end

  always @(posedge clk_i) begin
    cycles++;
    if (tr_req_o) tr_seen++;
    if (cm_req_o && cm_ack_i && log_n < 64) begin
      log_addr[log_n] <= cm_addr_o;
      log_op[log_n]   <= cm_op_o;
      log_n <= log_n + 1;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    chk(0, "watchdog", cycles, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // launch and wait; status: 1 done, 2 abort, 3 intr, 0 timeout
  task automatic walk(input logic [AW-1:0] sa, input logic [AW-1:0] ea,
                      input logic [1:0] op, output int st, output bit busy_after);
    log_n = 0; tr_seen = 0;
    @(negedge clk_i);
    start_addr_i = sa; end_addr_i = ea; op_i = op; launch_i = 1;
    @(negedge clk_i);
    launch_i = 0;
    busy_after = busy_o;
    st = 0;
    for (int i = 0; i < 1000; i++) begin
      if (done_o) begin st = 1; break; end
      if (abort_o) begin st = 2; break; end
      if (intr_o) begin st = 3; break; end
      @(negedge clk_i);
    end
    if (st != 0) begin
      @(negedge clk_i);
      chk(!(done_o || abort_o || intr_o), "R10 pulse one cycle", 1, 0);
    end
  endtask

  function automatic bit log_ok(input logic [AW-1:0] sa, input int n, input logic [1:0] op);
    for (int i = 0; i < n; i++)
      if (log_addr[i] != ((sa & ~32'h1f) + AW'(i) * 32) || log_op[i] != op) return 0;
    return 1;
  endfunction

  initial begin
    int st;
    bit bz;
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !tr_req_o && !cm_req_o && !done_o && !fault_o, "reset state", busy_o, 0);
    rst_ni = 1;

    // R1 R2 R3 R9 sweep: lines 8..13 with varying low bits, all ops and latencies
    for (int s = 0; s < 6; s++)
      for (int e = 0; e < 6; e++)
        for (int op = 1; op < 4; op++)
          for (int l = 0; l < 3; l++) begin
            logic [AW-1:0] sa, ea;
            int n;
            lat = l;
            sa = 32'h100 + AW'(s) * 32 + AW'((s * 7 + e * 3 + op) % 32);
            ea = 32'h100 + AW'(e) * 32 + AW'((e * 11 + s + l) % 32);
            walk(sa, ea, 2'(op), st, bz);
            chk(st == 1, "R2 R3 done status", st, 1);
            if (s > e) begin
              chk(log_n == 0 && tr_seen == 0 && !bz, "R3 empty range silent", log_n, 0);
            end else begin
              n = e - s + 1;
              chk(log_n == n, "R2 line count", log_n, n);
              chk(log_ok(sa, n, 2'(op)), "R1 R2 R9 line list and op", log_addr[0], sa & ~32'h1f);
              chk(bz, "R8 busy after launch", bz, 1);
            end
          end

    // R2 no wrap at top of address space
    lat = 1;
    walk(32'hFFFF_FFA7, 32'hFFFF_FFFF, 2'b11, st, bz);
    chk(st == 1 && log_n == 3, "R2 top lines count", log_n, 3);
    chk(log_ok(32'hFFFF_FFA0, 3, 2'b11), "R2 top lines list", log_addr[2], 32'hFFFF_FFE0);

    // R9 reserved opcode ignored
    log_n = 0; tr_seen = 0;
    @(negedge clk_i);
    start_addr_i = 32'h0; end_addr_i = 32'h80; op_i = 2'b00; launch_i = 1;
    @(negedge clk_i);
    launch_i = 0;
    begin
      int pulses = 0;
      for (int i = 0; i < 10; i++) begin
        if (busy_o || done_o || abort_o || intr_o) pulses++;
        @(negedge clk_i);
      end
      chk(pulses == 0 && tr_seen == 0, "R9 op 00 ignored", pulses, 0);
    end

    // R6 fault on each line position
    for (int f = 0; f < 4; f++) begin
      lat = f % 3;
      fault_en = 1; fault_line = 32'h2000 + AW'(f) * 32;
      walk(32'h2003, 32'h2060, 2'b10, st, bz);
      fault_en = 0;
      chk(st == 2, "R6 abort status", st, 2);
      chk(log_n == f && log_ok(32'h2000, f, 2'b10), "R6 lines before fault", log_n, f);
      chk(fault_o && fault_addr_o == fault_line, "R6 fault addr", fault_addr_o, fault_line);
    end
    // R6 next accepted launch clears fault
    walk(32'h40, 32'h20, 2'b01, st, bz);
    chk(!fault_o && fault_addr_o == 0, "R6 fault cleared", fault_addr_o, 0);

    // R7 interrupt after k lines, then full restart
    for (int k = 0; k < 4; k++) begin
      lat = (k + 1) % 3;
      irq_at = k;
      walk(32'h3010, 32'h3070, 2'b01, st, bz);
      irq_at = -1;
      chk(st == 3, "R7 intr status", st, 3);
      chk(log_n == k && !busy_o, "R7 lines before intr", log_n, k);
      walk(32'h3010, 32'h3070, 2'b01, st, bz);
      chk(st == 1 && log_n == 4 && log_ok(32'h3000, 4, 2'b01), "R7 restart from start", log_n, 4);
    end

    // R8 launch while busy ignored
    lat = 2; log_n = 0;
    @(negedge clk_i);
    start_addr_i = 32'h500; end_addr_i = 32'h560; op_i = 2'b11; launch_i = 1;
    @(negedge clk_i);
    launch_i = 0;
    repeat (3) @(negedge clk_i);
    start_addr_i = 32'h9000; end_addr_i = 32'h9000; op_i = 2'b01; launch_i = 1;
    @(negedge clk_i);
    launch_i = 0;
    st = 0;
    for (int i = 0; i < 500 && st == 0; i++) begin
      if (done_o) st = 1;
      else @(negedge clk_i);
    end
    chk(st == 1 && log_n == 4 && log_ok(32'h500, 4, 2'b11), "R8 busy launch ignored", log_n, 4);
    repeat (5) @(negedge clk_i);
    chk(!busy_o && log_n == 4, "R8 no second walk", log_n, 4);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule